// File: doc/BRIEF.md
# Sampled Input Glitch Filter

This block conditions one asynchronous timer input before it is used as a trigger or capture source. The raw pin is first brought into the kernel clock domain through a short synchronizer chain. The synchronized level is then sampled at a rate picked by a 4-bit filter code. The rate is either every kernel clock, every DTS clock-enable tick, or every 2, 4, 8, 16 or 32 DTS ticks. The filtered level moves to a new value only after a programmed number of consecutive samples all show that value.

A polarity bit is applied after filtering. The block drives three outputs, all synchronous to the kernel clock. The first is the filtered level with polarity applied. The second is a one-cycle pulse on each active edge. The third is a one-cycle pulse on every transition of the filtered signal, whatever the polarity. A timer's trigger selector or capture logic uses these outputs directly.

Top module: `tin_glitch_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, the internal filtered level is 0. `lvl_out` therefore equals `pol_inv`, and `act_edge` and `any_edge` are 0.
- R2: Codes 1, 2 and 3 sample on every kernel clock and need 2, 4 and 8 agreeing samples. The raw input passes through two synchronizer flops. With the code held steady, a change of `raw_in` driven before kernel edge 1 shows on `lvl_out` right after kernel edge 2+N.
- R3: Code 0 takes one sample per cycle in which `dts_tick` is high, and one sample at the new level is enough. With `dts_tick` held low, the filtered level does not move.
- R4: The DTS-divided codes sample on every 2^k-th `dts_tick`, with these pairs: 4 and 5 give k=1 with N=6 and 8; 6 and 7 give k=2 with N=6 and 8; 8 and 9 give k=3 with N=6 and 8; 10, 11 and 12 give k=4 with N=5, 6 and 8; 13, 14 and 15 give k=5 with N=5, 6 and 8. A pulse that spans fewer than N sample points is rejected. A pulse that spans at least N+1 sample periods is passed.
- R5: A sample equal to the current filtered level restarts the count of agreeing samples. A change in the output needs N consecutive samples at the new level.
- R6: `lvl_out` is the filtered level XOR `pol_inv`. With `pol_inv`=1, a low filtered level reads as active (1).
- R7: `any_edge` is high for exactly the one kernel cycle after each change of the filtered level, for either direction and either polarity setting. It is never high at any other time.
- R8: `act_edge` is high for one kernel cycle when a change of the filtered level makes `lvl_out` go from 0 to 1. A change of the filtered level in the other direction does not raise it.
- R9: In the kernel cycle where `flt_code` differs from its value on the previous cycle, no sample is taken. The sample divider and the agreement count restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| dts_tick | input | 1 | DTS-rate clock-enable, one kernel cycle per DTS period |
| raw_in | input | 1 | Asynchronous timer input |
| flt_code | input | 4 | Filter code selecting the sample rate and the agreement count |
| pol_inv | input | 1 | 0 means non-inverted, 1 means inverted |
| lvl_out | output | 1 | Filtered level after polarity |
| act_edge | output | 1 | One-cycle pulse on an active edge |
| any_edge | output | 1 | One-cycle pulse on every filtered transition |

## Verification
A wrong sample divider, or a wrong decode of the code, shifts the cycle in which `lvl_out` moves. It can also let a short glitch through or block a long pulse. This is seen within one transition, at the exact edge 2+N for kernel-rate codes, or within N+2 sample periods for divided codes. A count that is not restarted lets broken bursts through, and stale state kept across a code change makes the output move too early. Both are seen as an early `lvl_out` change a few cycles after the stimulus. Edge pulses that are stretched, missing or steered by polarity are seen in the cycle right after the transition.

// File: rtl/tgf_pkg.sv
package tgf_pkg;

    localparam int CODE_W          = 4;
    localparam int CNT_W           = 4;
    localparam int DIV_LOG2_W      = 3;
    localparam int MAX_DIV_LOG2    = 5;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        RATE_DTS    = 1'b0,
        RATE_KERNEL = 1'b1
    } tgf_rate_e;

    typedef struct packed {
        tgf_rate_e              rate;
        logic [DIV_LOG2_W-1:0]  div_log2;
        logic [CNT_W-1:0]       need;
    } tgf_cfg_t;

    // Sample rate and agreement count selected by the filter code.
    function automatic tgf_cfg_t tgf_decode(input logic [CODE_W-1:0] code);
        tgf_cfg_t c;
        c.rate     = RATE_DTS;
        c.div_log2 = '0;
        c.need     = CNT_W'(1);
        unique case (code)
            4'd0:  begin c.rate = RATE_DTS;    c.div_log2 = 3'd0; c.need = 4'd1; end
            4'd1:  begin c.rate = RATE_KERNEL; c.div_log2 = 3'd0; c.need = 4'd2; end
            4'd2:  begin c.rate = RATE_KERNEL; c.div_log2 = 3'd0; c.need = 4'd4; end
            4'd3:  begin c.rate = RATE_KERNEL; c.div_log2 = 3'd0; c.need = 4'd8; end
            4'd4:  begin c.div_log2 = 3'd1; c.need = 4'd6; end
            4'd5:  begin c.div_log2 = 3'd1; c.need = 4'd8; end
            4'd6:  begin c.div_log2 = 3'd2; c.need = 4'd6; end
            4'd7:  begin c.div_log2 = 3'd2; c.need = 4'd8; end
            4'd8:  begin c.div_log2 = 3'd3; c.need = 4'd6; end
            4'd9:  begin c.div_log2 = 3'd3; c.need = 4'd8; end
            4'd10: begin c.div_log2 = 3'd4; c.need = 4'd5; end
            4'd11: begin c.div_log2 = 3'd4; c.need = 4'd6; end
            4'd12: begin c.div_log2 = 3'd4; c.need = 4'd8; end
            4'd13: begin c.div_log2 = 3'd5; c.need = 4'd5; end
            4'd14: begin c.div_log2 = 3'd5; c.need = 4'd6; end
            default: begin c.div_log2 = 3'd5; c.need = 4'd8; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tgf_sync.sv
module tgf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= 1'b0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tgf_strobe.sv
module tgf_strobe
    import tgf_pkg::*;
#(
    parameter int DIV_W = MAX_DIV_LOG2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     dts_tick,
    input  tgf_cfg_t cfg,
    output logic     strobe
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] div_last;
    logic             wrap;

    always_comb begin
        span     = ({{DIV_W{1'b0}}, 1'b1} << cfg.div_log2) - 1'b1;
        div_last = span[DIV_W-1:0];
        wrap     = (div_cnt == div_last);
    end

    always_comb begin
        if (restart)                      strobe = 1'b0;
        else if (cfg.rate == RATE_KERNEL) strobe = 1'b1;
        else                              strobe = dts_tick && wrap;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_cnt <= '0;
        end else if (cfg.rate == RATE_DTS && dts_tick) begin
            div_cnt <= wrap ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tgf_confirm.sv
module tgf_confirm
    import tgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             strobe,
    input  logic             sample,
    input  logic [CNT_W-1:0] need,
    output logic             level
);
    logic [CNT_W-1:0] agree_cnt;
    logic [CNT_W:0]   next_cnt;
    logic             reached;

    always_comb begin
        next_cnt = {1'b0, agree_cnt} + 1'b1;
        reached  = (next_cnt >= {1'b0, need});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level     <= 1'b0;
            agree_cnt <= '0;
        end else if (restart) begin
            agree_cnt <= '0;
        end else if (strobe) begin
            if (sample == level) begin
                agree_cnt <= '0;
            end else if (reached) begin
                level     <= sample;
                agree_cnt <= '0;
            end else begin
                agree_cnt <= next_cnt[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tin_glitch_filter.sv
module tin_glitch_filter
    import tgf_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dts_tick,
    input  logic              raw_in,
    input  logic [CODE_W-1:0] flt_code,
    input  logic              pol_inv,
    output logic              lvl_out,
    output logic              act_edge,
    output logic              any_edge
);
    logic              sync_lvl;
    logic [CODE_W-1:0] code_q;
    logic              code_chg;
    tgf_cfg_t          cfg;
    logic              strobe;
    logic              filt_lvl;
    logic              filt_d;

    tgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_lvl)
    );

    always_ff @(posedge clk) begin
        code_q <= flt_code;
    end

    always_comb begin
        code_chg = (flt_code != code_q) && !rst;
        cfg      = tgf_decode(flt_code);
    end

    tgf_strobe #(.DIV_W(MAX_DIV_LOG2)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .restart  (code_chg),
        .dts_tick (dts_tick),
        .cfg      (cfg),
        .strobe   (strobe)
    );

    tgf_confirm u_confirm (
        .clk     (clk),
        .rst     (rst),
        .restart (code_chg),
        .strobe  (strobe),
        .sample  (sync_lvl),
        .need    (cfg.need),
        .level   (filt_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) filt_d <= 1'b0;
        else     filt_d <= filt_lvl;
    end

    always_comb begin
        any_edge = filt_lvl ^ filt_d;
        lvl_out  = filt_lvl ^ pol_inv;
        act_edge = any_edge && lvl_out;
    end
endmodule

// File: rtl/tgf_checker.sv
module tgf_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] flt_code,
    input logic       pol_inv,
    input logic       lvl_out,
    input logic       act_edge,
    input logic       any_edge,
    input logic       sync_lvl,
    input logic       filt_lvl
);
    a_r1_reset_level: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!filt_lvl && !any_edge && !act_edge));

    a_r5_new_level_sampled: assert property (@(posedge clk) disable iff (rst)
        (filt_lvl != $past(filt_lvl)) |-> ($past(sync_lvl) == filt_lvl));

    a_r7_pulse_marks_change: assert property (@(posedge clk) disable iff (rst)
        (any_edge && $stable(pol_inv)) |-> (lvl_out != $past(lvl_out)));

    a_r7_quiet_means_steady: assert property (@(posedge clk) disable iff (rst)
        (!any_edge && $stable(pol_inv)) |-> $stable(lvl_out));

    a_r8_active_is_edge: assert property (@(posedge clk) disable iff (rst)
        act_edge |-> (any_edge && lvl_out));

    a_r9_code_change_holds: assert property (@(posedge clk) disable iff (rst)
        (flt_code != $past(flt_code)) |=> $stable(filt_lvl));
endmodule

bind tin_glitch_filter tgf_checker i_tgf_checker (
    .clk      (clk),
    .rst      (rst),
    .flt_code (flt_code),
    .pol_inv  (pol_inv),
    .lvl_out  (lvl_out),
    .act_edge (act_edge),
    .any_edge (any_edge),
    .sync_lvl (sync_lvl),
    .filt_lvl (filt_lvl)
);

// File: tb/test_tin_glitch_filter.sv
module test_tin_glitch_filter;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dts_tick = 1'b0;
    logic       raw_in = 1'b0;
    logic [3:0] flt_code = 4'd1;
    logic       pol_inv = 1'b0;
    logic       lvl_out, act_edge, any_edge;

    int checks = 0;
    int errors = 0;
    int dts_per = 3;
    int dts_cnt = 0;
    bit dts_hold = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (dts_hold) begin
            dts_tick <= 1'b0;
        end else if (dts_cnt >= dts_per - 1) begin
            dts_cnt  <= 0;
            dts_tick <= 1'b1;
        end else begin
            dts_cnt  <= dts_cnt + 1;
            dts_tick <= 1'b0;
        end
    end

    tin_glitch_filter i_tin_glitch_filter (
        .clk      (clk),
        .rst      (rst),
        .dts_tick (dts_tick),
        .raw_in   (raw_in),
        .flt_code (flt_code),
        .pol_inv  (pol_inv),
        .lvl_out  (lvl_out),
        .act_edge (act_edge),
        .any_edge (any_edge)
    );

    function automatic int exp_n(input int code);
        int t[16] = '{1, 2, 4, 8, 6, 8, 6, 8, 6, 8, 5, 6, 8, 5, 6, 8};
        return t[code];
    endfunction

    function automatic int exp_period(input int code);
        if (code >= 1 && code <= 3) return 1;
        if (code == 0) return dts_per;
        if (code <= 5)  return 2 * dts_per;
        if (code <= 7)  return 4 * dts_per;
        if (code <= 9)  return 8 * dts_per;
        if (code <= 12) return 16 * dts_per;
        return 32 * dts_per;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_code(input int code);
        @(negedge clk);
        flt_code = 4'(code);
        wait_cycles(4);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        pol_inv = 1'b0;
        raw_in = 1'b0;
        wait_cycles(3);
        check(lvl_out == 1'b0, "R1", "lvl_out in reset", lvl_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check(lvl_out == 1'b0 && any_edge == 1'b0 && act_edge == 1'b0, "R1",
              "outputs after reset", {lvl_out, any_edge, act_edge}, 0);
    endtask

    task automatic t_kernel_latency(input int code);
        int first = 0;
        int n = exp_n(code);
        set_code(code);
        raw_in = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (lvl_out && first == 0) begin
                first = k;
                check(any_edge && act_edge, "R7", "pulses on rise",
                      {any_edge, act_edge}, 3);
                @(negedge clk);
                check(!any_edge && !act_edge, "R8", "pulse width one cycle",
                      {any_edge, act_edge}, 0);
                k++;
            end
        end
        check(first == 2 + n, "R2", $sformatf("rise latency code %0d", code), first, 2 + n);
        raw_in = 1'b0;
        first = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (!lvl_out && first == 0) begin
                first = k;
                check(any_edge && !act_edge, "R8", "fall gives no active pulse",
                      {any_edge, act_edge}, 2);
            end
        end
        check(first == 2 + n, "R2", $sformatf("fall latency code %0d", code), first, 2 + n);
    endtask

    task automatic t_pulse(input int code, input int width, input bit pass, input string req);
        int seen = 0;
        int edges = 0;
        int n = exp_n(code);
        int p = exp_period(code);
        set_code(code);
        raw_in = 1'b1;
        for (int i = 0; i < width; i++) begin
            @(negedge clk);
            if (lvl_out) seen = 1;
            if (any_edge) edges++;
        end
        raw_in = 1'b0;
        for (int i = 0; i < (n + 2) * p + 6; i++) begin
            @(negedge clk);
            if (lvl_out) seen = 1;
            if (any_edge) edges++;
        end
        check(seen == int'(pass), req, $sformatf("code %0d width %0d seen", code, width),
              seen, int'(pass));
        check(edges == (pass ? 2 : 0), "R7", $sformatf("code %0d edge count", code),
              edges, pass ? 2 : 0);
    endtask

    task automatic t_dts_hold();
        int seen = 0;
        set_code(0);
        dts_hold = 1'b1;
        @(negedge clk);
        raw_in = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (lvl_out) seen = 1;
        end
        check(seen == 0, "R3", "no sample without dts_tick", seen, 0);
        dts_hold = 1'b0;
        wait_cycles(2 * dts_per + 4);
        check(lvl_out == 1'b1, "R3", "single sample accepted", lvl_out, 1);
        raw_in = 1'b0;
        wait_cycles(2 * dts_per + 4);
        check(lvl_out == 1'b0, "R3", "returns low", lvl_out, 0);
    endtask

    task automatic t_restart();
        int seen = 0;
        set_code(3);
        for (int b = 0; b < 2; b++) begin
            raw_in = 1'b1;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (lvl_out) seen = 1;
            end
            raw_in = 1'b0;
            @(negedge clk);
            if (lvl_out) seen = 1;
        end
        wait_cycles(12);
        check(seen == 0, "R5", "broken burst rejected", seen, 0);
    endtask

    task automatic t_code_change();
        int first = 0;
        set_code(3);
        raw_in = 1'b1;
        wait_cycles(7);
        check(lvl_out == 1'b0, "R9", "not yet confirmed", lvl_out, 0);
        flt_code = 4'd2;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (lvl_out && first == 0) first = k;
        end
        check(first == 5, "R9", "count restarted by code change", first, 5);
        raw_in = 1'b0;
        wait_cycles(10);
    endtask

    task automatic t_polarity();
        int first = 0;
        set_code(1);
        pol_inv = 1'b1;
        @(negedge clk);
        check(lvl_out == 1'b1, "R6", "inverted idle level", lvl_out, 1);
        raw_in = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (!lvl_out && first == 0) begin
                first = k;
                check(any_edge && !act_edge, "R8", "inverted: rise not active",
                      {any_edge, act_edge}, 2);
            end
        end
        check(first == 4, "R6", "inverted level drops", first, 4);
        raw_in = 1'b0;
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (lvl_out && first == 0) begin
                first = k;
                check(any_edge && act_edge, "R8", "inverted: fall is active",
                      {any_edge, act_edge}, 3);
            end
        end
        check(first == 4, "R6", "inverted level rises", first, 4);
        pol_inv = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_all();
        t_reset();
        t_kernel_latency(1);
        t_kernel_latency(2);
        t_kernel_latency(3);
        t_dts_hold();
        t_pulse(0, 3, 1'b1, "R3");
        t_pulse(5, (exp_n(5) - 1) * exp_period(5) - 1, 1'b0, "R4");
        t_pulse(5, (exp_n(5) + 1) * exp_period(5), 1'b1, "R4");
        t_pulse(8, (exp_n(8) - 1) * exp_period(8) - 1, 1'b0, "R4");
        t_pulse(8, (exp_n(8) + 1) * exp_period(8), 1'b1, "R4");
        t_pulse(13, (exp_n(13) - 1) * exp_period(13) - 1, 1'b0, "R4");
        t_pulse(13, (exp_n(13) + 1) * exp_period(13), 1'b1, "R4");
        t_restart();
        t_code_change();
        t_polarity();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule